// File: doc/BRIEF.md
# Interrupt Error Aggregator with Stack Monitor

This block gathers the fault events that arise around interrupt handling and turns them into a stream of error records. It watches several sources: ECC results from vector and link-register reads and from context-restore reads, pass/fail results from the ISR entry and return checks, the interrupt stack pointer, and strobes for register parity, security and key violations. Each record carries a valid pulse, a 4-bit type code and the address tied to the fault.

Every type has its own sticky status bit and its own captured address. When several types are pending, the block reports them one per cycle in ascending code order. Low codes carry the high-severity faults. Software clears a sticky bit with a per-type write-one-to-clear strobe. The stack-warning bit is the exception: it follows the stack pointer against a programmable threshold, so it clears itself and ignores the clear strobe.

Two registered severity lines summarise the pending state for the next stage. That stage would typically raise a non-maskable interrupt.

Top module: `irq_err_collector`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, err_valid, sev_hi, sev_lo and err_status are all zero.
- R2: Each time a type's status bit goes from clear to set, exactly one record follows: err_valid is high for one cycle with err_code equal to the type code and err_addr equal to the captured address. It comes one cycle after the status bit sets when no lower-numbered type is waiting.
- R3: The type codes are as follows. High severity: 0 ISR entry fail, 1 vector/link double-bit ECC, 2 ISR return fail, 3 context-restore double-bit ECC, 4 stack at maximum, 5 register parity, 6 security violation. Low severity: 7 vector/link single-bit ECC, 8 context-restore single-bit ECC, 9 stack warning, 10 lock/key violation, 11 parity-diagnostic injection. err_status bit n holds type n.
- R4: A single-bit ECC result sets code 7 (vector/link) or code 8 (context restore). A double-bit result sets code 1 or code 3. If both results arrive on the same source in the same cycle, only the double-bit type is set.
- R5: When several types become pending together, one record per cycle is produced, in ascending code order.
- R6: A sticky status bit (every type except 9) stays set after its record has been issued. It clears only on the cycle after err_clr bit n is strobed.
- R7: A new event for a type that is already pending and not cleared produces no further record. If the event arrives in the same cycle as that type's clear strobe, the bit stays set and a fresh record is issued with the new address.
- R8: Status bit 9 is set one cycle after isp >= warn_thresh and clears one cycle after isp < warn_thresh. err_clr bit 9 has no effect on it. Its address is the stack pointer value.
- R9: isp equal to the maximum depth of 15 sets sticky type 4, with the stack pointer value as its address.
- R10: sev_hi is the registered OR of pending types 0 to 6, and sev_lo is the registered OR of pending types 7 to 11. Each follows err_status by one cycle.
- R11: Addresses come from these inputs: vec_addr for codes 1 and 7, ctx_addr for codes 3 and 8, isr_addr for codes 0 and 2, reg_addr for codes 5, 6, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_ecc_sb | input | 1 | Single-bit ECC on vector or link read |
| vec_ecc_db | input | 1 | Double-bit ECC on vector or link read |
| vec_addr | input | 32 | Address of the vector or link read |
| ctx_ecc_sb | input | 1 | Single-bit ECC on context-restore read |
| ctx_ecc_db | input | 1 | Double-bit ECC on context-restore read |
| ctx_addr | input | 32 | Address of the context-restore read |
| isr_entry_bad | input | 1 | ISR entry check failed |
| isr_ret_bad | input | 1 | ISR return check failed |
| isr_addr | input | 32 | Address of the checked ISR packet |
| reg_par_err | input | 1 | Register parity mismatch |
| reg_sec_err | input | 1 | Unsecure register access |
| reg_key_err | input | 1 | Locked write or wrong key |
| par_diag_err | input | 1 | Injected parity-diagnostic error |
| reg_addr | input | 32 | Register address for register faults |
| isp | input | 4 | Current interrupt stack pointer |
| warn_thresh | input | 4 | Stack warning threshold |
| err_clr | input | 12 | Per-type write-one-to-clear strobes |
| err_valid | output | 1 | Record valid pulse |
| err_code | output | 4 | Record type code |
| err_addr | output | 32 | Record address |
| sev_hi | output | 1 | Any high-severity type pending |
| sev_lo | output | 1 | Any low-severity type pending |
| err_status | output | 12 | Per-type status bits |

## Verification
Two functions can land in the same cycle. The first is the arrival of a new event for a type and the clear strobe for that same type. The bench provokes this by driving a fresh ISR entry failure with a new address together with err_clr bit 0. It judges the result by requiring that the status bit survives and that one further record with the new address is issued. The second is arbitration among types that arrive together, including a stack pointer of 15 that raises the maximum-depth and warning types at once. The scoreboard queue holds the expected records in ascending code order and rejects any extra or reordered record.

// File: rtl/irqerr_pkg.sv
package irqerr_pkg;
  localparam int NTYPES = 12;
  localparam int CW     = 4;

  typedef enum logic [CW-1:0] {
    T_ENTRY   = 4'd0,
    T_VEC_UE  = 4'd1,
    T_RET     = 4'd2,
    T_CTX_UE  = 4'd3,
    T_STK_MAX = 4'd4,
    T_PARITY  = 4'd5,
    T_SECURE  = 4'd6,
    T_VEC_CE  = 4'd7,
    T_CTX_CE  = 4'd8,
    T_STK_WRN = 4'd9,
    T_KEY     = 4'd10,
    T_PDIAG   = 4'd11
  } err_type_e;

  // high-severity types occupy the low codes
  localparam logic [NTYPES-1:0] HI_MASK  = 12'h07F;
  // types whose status follows a level instead of being sticky
  localparam logic [NTYPES-1:0] LVL_MASK = 12'h200;
endpackage

// File: rtl/irqerr_stack_mon.sv
module irqerr_stack_mon #(
  parameter int SPW    = 4,
  parameter int SP_MAX = 15
) (
  input  logic [SPW-1:0] isp,
  input  logic [SPW-1:0] warn_thresh,
  output logic           warn_lvl,
  output logic           max_hit
);
  localparam logic [SPW-1:0] MAX_V = SPW'(SP_MAX);

  always_comb begin
    warn_lvl = (isp >= warn_thresh);
    max_hit  = (isp >= MAX_V);
  end
endmodule

// File: rtl/irqerr_classify.sv
module irqerr_classify
  import irqerr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SPW = 4
) (
  input  logic                       vec_ecc_sb,
  input  logic                       vec_ecc_db,
  input  logic [AW-1:0]              vec_addr,
  input  logic                       ctx_ecc_sb,
  input  logic                       ctx_ecc_db,
  input  logic [AW-1:0]              ctx_addr,
  input  logic                       isr_entry_bad,
  input  logic                       isr_ret_bad,
  input  logic [AW-1:0]              isr_addr,
  input  logic                       reg_par_err,
  input  logic                       reg_sec_err,
  input  logic                       reg_key_err,
  input  logic                       par_diag_err,
  input  logic [AW-1:0]              reg_addr,
  input  logic [SPW-1:0]             isp,
  input  logic                       warn_lvl,
  input  logic                       max_hit,
  output logic [NTYPES-1:0]          set_vec,
  output logic [NTYPES-1:0][AW-1:0]  set_addr
);
  logic [AW-1:0] sp_addr;

  always_comb begin
    sp_addr  = {{(AW-SPW){1'b0}}, isp};
    set_vec  = '0;
    set_addr = '0;

    set_vec[T_ENTRY]   = isr_entry_bad;
    set_addr[T_ENTRY]  = isr_addr;
    set_vec[T_RET]     = isr_ret_bad;
    set_addr[T_RET]    = isr_addr;

    // double-bit result dominates on the same source
    set_vec[T_VEC_UE]  = vec_ecc_db;
    set_addr[T_VEC_UE] = vec_addr;
    set_vec[T_VEC_CE]  = vec_ecc_sb & ~vec_ecc_db;
    set_addr[T_VEC_CE] = vec_addr;
    set_vec[T_CTX_UE]  = ctx_ecc_db;
    set_addr[T_CTX_UE] = ctx_addr;
    set_vec[T_CTX_CE]  = ctx_ecc_sb & ~ctx_ecc_db;
    set_addr[T_CTX_CE] = ctx_addr;

    set_vec[T_STK_MAX]  = max_hit;
    set_addr[T_STK_MAX] = sp_addr;
    set_vec[T_STK_WRN]  = warn_lvl;
    set_addr[T_STK_WRN] = sp_addr;

    set_vec[T_PARITY]  = reg_par_err;
    set_addr[T_PARITY] = reg_addr;
    set_vec[T_SECURE]  = reg_sec_err;
    set_addr[T_SECURE] = reg_addr;
    set_vec[T_KEY]     = reg_key_err;
    set_addr[T_KEY]    = reg_addr;
    set_vec[T_PDIAG]   = par_diag_err;
    set_addr[T_PDIAG]  = reg_addr;
  end
endmodule

// File: rtl/irqerr_status.sv
module irqerr_status
  import irqerr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTYPES-1:0]          set_vec,
  input  logic [NTYPES-1:0][AW-1:0]  set_addr,
  input  logic [NTYPES-1:0]          clr,
  input  logic [NTYPES-1:0]          grant,
  output logic [NTYPES-1:0]          stat_q,
  output logic [NTYPES-1:0]          pend,
  output logic [NTYPES-1:0][AW-1:0]  addr_q
);
  logic [NTYPES-1:0] stat_d;
  logic [NTYPES-1:0] rep_q, rep_d;
  logic [NTYPES-1:0] clr_eff;
  logic [NTYPES-1:0] addr_we;

  for (genvar t = 0; t < NTYPES; t++) begin : g_type
    if (LVL_MASK[t]) begin : g_lvl
      always_comb begin
        clr_eff[t]  = 1'b0;
        stat_d[t]   = set_vec[t];
        addr_we[t]  = set_vec[t] & ~stat_q[t];
      end
      // R8
      wrn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[t] |=> stat_q[t]);
      // R8
      wrn_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_vec[t] |=> !stat_q[t]);
    end else begin : g_stk
      always_comb begin
        clr_eff[t]  = clr[t];
        stat_d[t]   = set_vec[t] | (stat_q[t] & ~clr[t]);
        addr_we[t]  = set_vec[t] & (~stat_q[t] | clr[t]);
      end
      // R6
      sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[t] |=> stat_q[t]);
      // R6
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[t] && !set_vec[t]) |=> !stat_q[t]);
      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[t] && !clr[t]) |=> stat_q[t]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[t] <= '0;
      end else if (addr_we[t]) begin
        addr_q[t] <= set_addr[t];
      end
    end
  end

  always_comb begin
    rep_d = (rep_q | grant) & stat_d & ~clr_eff;
    pend  = stat_q & ~rep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      rep_q  <= '0;
    end else begin
      stat_q <= stat_d;
      rep_q  <= rep_d;
    end
  end

  // R7
  no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & rep_q) == '0);
endmodule

// File: rtl/irqerr_report.sv
module irqerr_report
  import irqerr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTYPES-1:0]          stat_q,
  input  logic [NTYPES-1:0]          pend,
  input  logic [NTYPES-1:0][AW-1:0]  addr_q,
  output logic [NTYPES-1:0]          grant,
  output logic                       rec_vld_q,
  output logic [CW-1:0]              rec_code_q,
  output logic [AW-1:0]              rec_addr_q,
  output logic                       sev_hi_q,
  output logic                       sev_lo_q
);
  logic          found;
  logic [CW-1:0] sel;
  logic          sev_hi_d, sev_lo_d;

  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NTYPES; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        sel      = CW'(i);
        found    = 1'b1;
      end
    end
    sev_hi_d = |(stat_q & HI_MASK);
    sev_lo_d = |(stat_q & ~HI_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld_q  <= 1'b0;
      rec_code_q <= '0;
      rec_addr_q <= '0;
      sev_hi_q   <= 1'b0;
      sev_lo_q   <= 1'b0;
    end else begin
      rec_vld_q <= found;
      sev_hi_q  <= sev_hi_d;
      sev_lo_q  <= sev_lo_d;
      if (found) begin
        rec_code_q <= sel;
        rec_addr_q <= addr_q[sel];
      end
    end
  end

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R2
  rec_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld_q |-> (($past(pend) & (NTYPES'(1) << rec_code_q)) != '0));
  // R10
  sev_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & HI_MASK) != '0) |=> sev_hi_q);
  // R10
  sev_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |=> (!sev_hi_q && !sev_lo_q));
endmodule

// File: rtl/irq_err_collector.sv
module irq_err_collector
  import irqerr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SPW    = 4,
  parameter int SP_MAX = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_ecc_sb,
  input  logic              vec_ecc_db,
  input  logic [AW-1:0]     vec_addr,
  input  logic              ctx_ecc_sb,
  input  logic              ctx_ecc_db,
  input  logic [AW-1:0]     ctx_addr,
  input  logic              isr_entry_bad,
  input  logic              isr_ret_bad,
  input  logic [AW-1:0]     isr_addr,
  input  logic              reg_par_err,
  input  logic              reg_sec_err,
  input  logic              reg_key_err,
  input  logic              par_diag_err,
  input  logic [AW-1:0]     reg_addr,
  input  logic [SPW-1:0]    isp,
  input  logic [SPW-1:0]    warn_thresh,
  input  logic [NTYPES-1:0] err_clr,
  output logic              err_valid,
  output logic [CW-1:0]     err_code,
  output logic [AW-1:0]     err_addr,
  output logic              sev_hi,
  output logic              sev_lo,
  output logic [NTYPES-1:0] err_status
);
  localparam logic [SPW-1:0] MAX_V = SPW'(SP_MAX);

  logic                      rst_s1_q, rst_s2_q;
  logic                      warn_lvl, max_hit;
  logic [NTYPES-1:0]         set_vec;
  logic [NTYPES-1:0][AW-1:0] set_addr;
  logic [NTYPES-1:0]         grant;
  logic [NTYPES-1:0]         stat_q;
  logic [NTYPES-1:0]         pend;
  logic [NTYPES-1:0][AW-1:0] addr_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  irqerr_stack_mon #(.SPW(SPW), .SP_MAX(SP_MAX)) u_stk (
    .isp         (isp),
    .warn_thresh (warn_thresh),
    .warn_lvl    (warn_lvl),
    .max_hit     (max_hit)
  );

  irqerr_classify #(.AW(AW), .SPW(SPW)) u_cls (
    .vec_ecc_sb    (vec_ecc_sb),
    .vec_ecc_db    (vec_ecc_db),
    .vec_addr      (vec_addr),
    .ctx_ecc_sb    (ctx_ecc_sb),
    .ctx_ecc_db    (ctx_ecc_db),
    .ctx_addr      (ctx_addr),
    .isr_entry_bad (isr_entry_bad),
    .isr_ret_bad   (isr_ret_bad),
    .isr_addr      (isr_addr),
    .reg_par_err   (reg_par_err),
    .reg_sec_err   (reg_sec_err),
    .reg_key_err   (reg_key_err),
    .par_diag_err  (par_diag_err),
    .reg_addr      (reg_addr),
    .isp           (isp),
    .warn_lvl      (warn_lvl),
    .max_hit       (max_hit),
    .set_vec       (set_vec),
    .set_addr      (set_addr)
  );

  irqerr_status #(.AW(AW)) u_sts (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .set_vec  (set_vec),
    .set_addr (set_addr),
    .clr      (err_clr),
    .grant    (grant),
    .stat_q   (stat_q),
    .pend     (pend),
    .addr_q   (addr_q)
  );

  irqerr_report #(.AW(AW)) u_rep (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .stat_q     (stat_q),
    .pend       (pend),
    .addr_q     (addr_q),
    .grant      (grant),
    .rec_vld_q  (err_valid),
    .rec_code_q (err_code),
    .rec_addr_q (err_addr),
    .sev_hi_q   (sev_hi),
    .sev_lo_q   (sev_lo)
  );

  assign err_status = stat_q;

  // R9
  stk_max_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (isp == MAX_V) |=> err_status[T_STK_MAX]);
  // R4
  db_over_sb_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (vec_ecc_db && !err_status[T_VEC_CE] && !err_clr[T_VEC_CE]) |=> !err_status[T_VEC_CE]);
endmodule

// File: tb/irq_err_collector_tb_top.sv
module irq_err_collector_tb_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0]  code;
    logic [31:0] addr;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vec_ecc_sb, vec_ecc_db, ctx_ecc_sb, ctx_ecc_db;
  logic [31:0] vec_addr, ctx_addr, isr_addr, reg_addr;
  logic        isr_entry_bad, isr_ret_bad;
  logic        reg_par_err, reg_sec_err, reg_key_err, par_diag_err;
  logic [3:0]  isp, warn_thresh;
  logic [11:0] err_clr;
  logic        err_valid, sev_hi, sev_lo;
  logic [3:0]  err_code;
  logic [31:0] err_addr;
  logic [11:0] err_status;

  rec_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_err_collector dut_i (
    .clk (clk), .rst_n (rst_n),
    .vec_ecc_sb (vec_ecc_sb), .vec_ecc_db (vec_ecc_db), .vec_addr (vec_addr),
    .ctx_ecc_sb (ctx_ecc_sb), .ctx_ecc_db (ctx_ecc_db), .ctx_addr (ctx_addr),
    .isr_entry_bad (isr_entry_bad), .isr_ret_bad (isr_ret_bad), .isr_addr (isr_addr),
    .reg_par_err (reg_par_err), .reg_sec_err (reg_sec_err),
    .reg_key_err (reg_key_err), .par_diag_err (par_diag_err), .reg_addr (reg_addr),
    .isp (isp), .warn_thresh (warn_thresh), .err_clr (err_clr),
    .err_valid (err_valid), .err_code (err_code), .err_addr (err_addr),
    .sev_hi (sev_hi), .sev_lo (sev_lo), .err_status (err_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_rec(input logic [3:0] code, input logic [31:0] addr);
    rec_t r;
    r.code = code;
    r.addr = addr;
    exp_q.push_back(r);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    vec_ecc_sb = 0; vec_ecc_db = 0; ctx_ecc_sb = 0; ctx_ecc_db = 0;
    isr_entry_bad = 0; isr_ret_bad = 0;
    reg_par_err = 0; reg_sec_err = 0; reg_key_err = 0; par_diag_err = 0;
    err_clr = '0;
  endtask

  // monitor: pop and compare each record as it appears
  always @(negedge clk) begin
    rec_t e;
    if (rst_n === 1'b1 && err_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R2 unexpected record actual=%0d/%h expected=none", err_code, err_addr);
      end else begin
        e = exp_q.pop_front();
        chk("R2 R5 record code/addr", {28'd0, err_code, err_addr}, {28'd0, e.code, e.addr});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    quiet();
    vec_addr = '0; ctx_addr = '0; isr_addr = '0; reg_addr = '0;
    isp = 4'd0; warn_thresh = 4'd8;
    rst_n = 1'b0;
    tick(3);
    chk("R1 valid in reset", {63'd0, err_valid}, 64'd0);
    chk("R1 status in reset", {52'd0, err_status}, 64'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 sev after reset", {62'd0, sev_hi, sev_lo}, 64'd0);
    chk("R1 status after reset", {52'd0, err_status}, 64'd0);

    // R4 R11: double-bit on vector read
    vec_ecc_db = 1; vec_addr = 32'h0000_1100;
    expect_rec(4'd1, 32'h0000_1100);
    tick(1); quiet();
    chk("R4 vec double-bit status", {52'd0, err_status}, 64'h002);
    tick(1);
    chk("R10 sev after high", {62'd0, sev_hi, sev_lo}, 64'd2);
    tick(3);
    chk("R6 sticky after report", {52'd0, err_status}, 64'h002);
    err_clr = 12'h002; tick(1); quiet();
    chk("R6 cleared by strobe", {52'd0, err_status}, 64'h000);
    tick(1);
    chk("R10 sev drops", {62'd0, sev_hi, sev_lo}, 64'd0);

    // R4: both on same source
    vec_ecc_sb = 1; vec_ecc_db = 1; vec_addr = 32'h0000_2200;
    expect_rec(4'd1, 32'h0000_2200);
    tick(1); quiet();
    chk("R4 double wins over single", {52'd0, err_status}, 64'h002);
    tick(3);
    err_clr = 12'h002; tick(1); quiet();

    // R4 R3: single-bit on vector read is low severity
    vec_ecc_sb = 1; vec_addr = 32'h0000_3300;
    expect_rec(4'd7, 32'h0000_3300);
    tick(1); quiet();
    chk("R4 vec single-bit status", {52'd0, err_status}, 64'h080);
    tick(1);
    chk("R3 R10 low only", {62'd0, sev_hi, sev_lo}, 64'd1);
    tick(3);
    err_clr = 12'h080; tick(1); quiet();

    // R5 R11: four types at once
    isr_entry_bad = 1; isr_addr = 32'hB000_0000;
    reg_par_err = 1; reg_key_err = 1; reg_addr = 32'hC000_0000;
    ctx_ecc_sb = 1; ctx_addr = 32'hD000_0000;
    expect_rec(4'd0, 32'hB000_0000);
    expect_rec(4'd5, 32'hC000_0000);
    expect_rec(4'd8, 32'hD000_0000);
    expect_rec(4'd10, 32'hC000_0000);
    tick(1); quiet();
    chk("R5 combined status", {52'd0, err_status}, 64'h521);
    tick(6);
    chk("R10 both severities", {62'd0, sev_hi, sev_lo}, 64'd3);

    // R7: repeat while pending gives no record
    isr_entry_bad = 1; isr_addr = 32'hBEEF_0000;
    tick(1); quiet();
    tick(3);
    chk("R7 no record on repeat", {63'd0, err_valid}, 64'd0);

    // R7: event and clear together re-report with new address
    isr_entry_bad = 1; isr_addr = 32'hE000_0004; err_clr = 12'h001;
    expect_rec(4'd0, 32'hE000_0004);
    tick(1); quiet();
    chk("R7 set beats clear", {63'd0, err_status[0]}, 64'd1);
    tick(3);
    err_clr = 12'hFFF; tick(1); quiet();
    chk("R6 clear all", {52'd0, err_status}, 64'h000);
    tick(2);

    // R8: warning follows stack pointer
    isp = 4'd8;
    expect_rec(4'd9, 32'd8);
    tick(1);
    chk("R8 warn set at threshold", {52'd0, err_status}, 64'h200);
    tick(3);
    err_clr = 12'h200; tick(1); quiet();
    tick(1);
    chk("R8 clear ignored", {52'd0, err_status}, 64'h200);
    isp = 4'd7; tick(1);
    chk("R8 self clear below", {52'd0, err_status}, 64'h000);
    tick(1);
    chk("R10 low drops", {62'd0, sev_hi, sev_lo}, 64'd0);

    // R9 R5: max depth raises max and warn together
    isp = 4'd15;
    expect_rec(4'd4, 32'd15);
    expect_rec(4'd9, 32'd15);
    tick(1);
    chk("R9 max and warn", {52'd0, err_status}, 64'h210);
    tick(3);
    isp = 4'd3; tick(1);
    chk("R9 max stays sticky", {52'd0, err_status}, 64'h010);
    err_clr = 12'h010; tick(1); quiet();
    chk("R9 max cleared", {52'd0, err_status}, 64'h000);

    // R5 R11 R3: return, ctx double, security, diag
    isr_ret_bad = 1; isr_addr = 32'hF000_0000;
    ctx_ecc_db = 1; ctx_addr = 32'h6000_0000;
    reg_sec_err = 1; par_diag_err = 1; reg_addr = 32'h7000_0000;
    expect_rec(4'd2, 32'hF000_0000);
    expect_rec(4'd3, 32'h6000_0000);
    expect_rec(4'd6, 32'h7000_0000);
    expect_rec(4'd11, 32'h7000_0000);
    tick(1); quiet();
    chk("R3 second group status", {52'd0, err_status}, 64'h84C);
    tick(6);
    err_clr = 12'hFFF; tick(1); quiet();
    tick(3);
    chk("R6 final clear", {52'd0, err_status}, 64'h000);
    chk("R2 all records seen", 64'(exp_q.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule